// File: doc/BRIEF.md
# Memory Access Permission Checker

This block judges one memory access against an already translated page or section entry and the current protection control state. For each request it decides whether the access may proceed or must abort. On an abort it gives the fault class, whether the abort belongs to an instruction fetch or a data access, and whether the entry was a page or a section. It also marks the access as uncacheable when that applies. The address translation itself is done elsewhere. The block only takes the entry fields that the lookup produced.

The decision is built from a chain of checks. The alignment check runs first. The per-domain access code comes next, taken from the 32-bit domain register. Last comes a three-bit access permission table. That table has a legacy override for permission code 0 and an execute-never rule for fetches. The decision is combinational. It is captured in a result register, so a response appears one clock after the request with a valid flag.

Top module: `perm_check_top`

## Requirements
- R1: A read or write (acc_kind 0 or 1) raises an alignment fault when two conditions both hold. First, align_check_en is 1 or allow_unaligned is 0. Second, vaddr AND align_mask is nonzero. The fault reports rsp_class 1 and rsp_prefetch 0. An alignment fault takes priority over all other checks. A fetch (acc_kind 2) never raises an alignment fault.
- R2: The access code for an entry is the two bits dom_access[2*ent_domain+1 : 2*ent_domain].
- R3: Access code 0 gives a domain fault with rsp_class 2. rsp_prefetch is 1 for a fetch and 0 otherwise.
- R4: Access code 3 passes the access with no permission or execute-never check.
- R5: Access code 2 gives rsp_class 3 with rsp_unpred set.
- R6: When ap_force_en is 1, bit 0 of ent_ap is forced to 1 before the permission table is applied.
- R7: Under access code 1, the permission codes abort as follows. An unprivileged access is one with priv_mode 0.
  - Code 1 aborts unprivileged accesses.
  - Code 2 aborts unprivileged writes.
  - Code 3 never aborts.
  - Code 5 aborts unprivileged accesses and all writes.
  - Codes 6 and 7 abort writes.
  - Every permission abort reports rsp_class 3.
- R8: Permission code 0 always aborts when xp_en is 1. When xp_en is 0, rs_sel decides:
  - rs_sel 2 aborts writes.
  - rs_sel 1 aborts writes and unprivileged accesses.
  - rs_sel 0 and 3 always abort.
- R9: Permission code 4 gives rsp_class 3 with rsp_unpred set.
- R10: Under access code 1, a fetch with ent_xn set faults with rsp_class 3 and rsp_prefetch 1. A permission fault on a read or write has rsp_prefetch 0.
- R11: rsp_page copies ent_page on domain and permission faults. It is 0 when there is no fault and on an alignment fault.
- R12: With mmu_en 0, no domain or permission check is made, and rsp_uncached is the inverse of remap_en. With mmu_en 1, rsp_uncached equals ent_nocache.
- R13: rsp_valid is 1 exactly one cycle after req_valid was 1. While no request arrives, the result outputs keep their last values. After reset all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| acc_kind | input | 2 | 0 read, 1 write, 2 fetch (3 acts as read) |
| priv_mode | input | 1 | 1 privileged, 0 unprivileged |
| allow_unaligned | input | 1 | Request tolerates unaligned addresses |
| align_mask | input | ADDR_W | Low-bit mask for the alignment test |
| vaddr | input | ADDR_W | Virtual address |
| ent_domain | input | DOM_W | Entry domain number |
| ent_ap | input | 3 | Entry permission code |
| ent_xn | input | 1 | Entry execute-never |
| ent_page | input | 1 | 1 page entry, 0 section entry |
| ent_nocache | input | 1 | Entry non-cacheable |
| dom_access | input | 2*NUM_DOM | Two-bit access code per domain |
| align_check_en | input | 1 | Force alignment checking |
| mmu_en | input | 1 | Translation and protection enable |
| ap_force_en | input | 1 | Force permission bit 0 |
| xp_en | input | 1 | Newer permission model for code 0 |
| rs_sel | input | 2 | Legacy override for permission code 0 |
| remap_en | input | 1 | Attribute remap enable (used with mmu_en 0) |
| rsp_valid | output | 1 | Result valid |
| rsp_fault | output | 1 | Access aborts |
| rsp_class | output | 2 | 0 none, 1 alignment, 2 domain, 3 permission |
| rsp_prefetch | output | 1 | 1 prefetch abort, 0 data abort |
| rsp_page | output | 1 | Page/section indication of the fault |
| rsp_uncached | output | 1 | Access is uncacheable |
| rsp_unpred | output | 1 | Fault caused by an unpredictable encoding |

## Verification
The assertions check several invariants on every cycle:
- the one-cycle response timing and the holding of results while idle;
- that an alignment fault is never a prefetch abort;
- that an unpredictable flag always comes with a permission fault;
- that page and prefetch indications stay clear without a fault;
- that a manager domain or a disabled MMU never produces a non-alignment fault.

Some behaviours can only be shown by the bench's scenarios:
- that the right two-bit field of the domain register is selected;
- the full permission table across privilege and write combinations;
- the code 0 override selected by rs_sel;
- the forcing of permission bit 0;
- the ordering between the alignment, domain and permission checks.

// File: rtl/perm_chk_pkg.sv
package perm_chk_pkg;

    typedef enum logic [1:0] {
        CLS_NONE  = 2'd0,
        CLS_ALIGN = 2'd1,
        CLS_DOM   = 2'd2,
        CLS_PERM  = 2'd3
    } fault_cls_e;

    typedef enum logic [1:0] {
        ACC_READ  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_FETCH = 2'd2
    } acc_kind_e;

    localparam logic [1:0] DCODE_NOACC   = 2'd0;
    localparam logic [1:0] DCODE_CLIENT  = 2'd1;
    localparam logic [1:0] DCODE_RSVD    = 2'd2;
    localparam logic [1:0] DCODE_MANAGER = 2'd3;

    typedef struct packed {
        logic       fault;
        fault_cls_e cls;
        logic       prefetch;
        logic       page;
        logic       uncached;
        logic       unpred;
    } chk_res_t;

    typedef struct packed {
        logic     vld;
        chk_res_t res;
    } chk_state_t;

endpackage

// File: rtl/perm_align_chk.sv
module perm_align_chk #(
    parameter int ADDR_W = 32
) (
    input  logic              is_fetch,
    input  logic              chk_en,
    input  logic              allow_unaligned,
    input  logic [ADDR_W-1:0] vaddr,
    input  logic [ADDR_W-1:0] mask,
    output logic              misalign
);
    logic enforce;
    logic low_bits_set;

    always_comb begin
        enforce      = chk_en || !allow_unaligned;
        low_bits_set = |(vaddr & mask);
        misalign     = !is_fetch && enforce && low_bits_set;
    end
endmodule

// File: rtl/perm_domain_sel.sv
module perm_domain_sel #(
    parameter int NUM_DOM = 16,
    localparam int DOM_W  = $clog2(NUM_DOM),
    localparam int DACR_W = 2 * NUM_DOM
) (
    input  logic [DACR_W-1:0] dom_access,
    input  logic [DOM_W-1:0]  domain,
    output logic [1:0]        code
);
    logic [1:0] codes [NUM_DOM];

    for (genvar g = 0; g < NUM_DOM; g++) begin : g_split
        assign codes[g] = dom_access[2*g +: 2];
    end

    assign code = codes[domain];
endmodule

// File: rtl/perm_ap_table.sv
module perm_ap_table (
    input  logic [2:0] ap_raw,
    input  logic       force_bit0,
    input  logic       priv,
    input  logic       is_write,
    input  logic       xp_en,
    input  logic [1:0] rs_sel,
    output logic       abort,
    output logic       unpred
);
    logic [2:0] ap_eff;

    always_comb begin
        ap_eff = ap_raw | {2'b00, force_bit0};
        abort  = 1'b0;
        unpred = 1'b0;
        case (ap_eff)
            3'd0: begin
                if (xp_en) begin
                    abort = 1'b1;
                end else begin
                    case (rs_sel)
                        2'd2:    abort = is_write;
                        2'd1:    abort = is_write || !priv;
                        default: abort = 1'b1;
                    endcase
                end
            end
            3'd1:    abort = !priv;
            3'd2:    abort = !priv && is_write;
            3'd3:    abort = 1'b0;
            3'd4:    unpred = 1'b1;
            3'd5:    abort = !priv || is_write;
            default: abort = is_write;
        endcase
    end
endmodule

// File: rtl/perm_check_top.sv
module perm_check_top
    import perm_chk_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int NUM_DOM = 16,
    localparam int DOM_W  = $clog2(NUM_DOM),
    localparam int DACR_W = 2 * NUM_DOM
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [1:0]        acc_kind,
    input  logic              priv_mode,
    input  logic              allow_unaligned,
    input  logic [ADDR_W-1:0] align_mask,
    input  logic [ADDR_W-1:0] vaddr,
    input  logic [DOM_W-1:0]  ent_domain,
    input  logic [2:0]        ent_ap,
    input  logic              ent_xn,
    input  logic              ent_page,
    input  logic              ent_nocache,
    input  logic [DACR_W-1:0] dom_access,
    input  logic              align_check_en,
    input  logic              mmu_en,
    input  logic              ap_force_en,
    input  logic              xp_en,
    input  logic [1:0]        rs_sel,
    input  logic              remap_en,
    output logic              rsp_valid,
    output logic              rsp_fault,
    output logic [1:0]        rsp_class,
    output logic              rsp_prefetch,
    output logic              rsp_page,
    output logic              rsp_uncached,
    output logic              rsp_unpred
);
    logic       is_fetch;
    logic       is_write;
    logic       misalign;
    logic [1:0] dom_code;
    logic       ap_abort;
    logic       ap_unpred;
    chk_res_t   res;
    chk_state_t s_d, s_q;

    assign is_fetch = (acc_kind == ACC_FETCH);
    assign is_write = (acc_kind == ACC_WRITE);

    perm_align_chk #(.ADDR_W(ADDR_W)) i_align (
        .is_fetch        (is_fetch),
        .chk_en          (align_check_en),
        .allow_unaligned (allow_unaligned),
        .vaddr           (vaddr),
        .mask            (align_mask),
        .misalign        (misalign)
    );

    perm_domain_sel #(.NUM_DOM(NUM_DOM)) i_dom (
        .dom_access (dom_access),
        .domain     (ent_domain),
        .code       (dom_code)
    );

    perm_ap_table i_ap (
        .ap_raw     (ent_ap),
        .force_bit0 (ap_force_en),
        .priv       (priv_mode),
        .is_write   (is_write),
        .xp_en      (xp_en),
        .rs_sel     (rs_sel),
        .abort      (ap_abort),
        .unpred     (ap_unpred)
    );

    always_comb begin
        res          = '0;
        res.cls      = CLS_NONE;
        res.uncached = mmu_en ? ent_nocache : !remap_en;
        if (misalign) begin
            res.fault = 1'b1;
            res.cls   = CLS_ALIGN;
        end else if (mmu_en) begin
            case (dom_code)
                DCODE_NOACC: begin
                    res.fault    = 1'b1;
                    res.cls      = CLS_DOM;
                    res.prefetch = is_fetch;
                    res.page     = ent_page;
                end
                DCODE_RSVD: begin
                    res.fault    = 1'b1;
                    res.cls      = CLS_PERM;
                    res.unpred   = 1'b1;
                    res.prefetch = is_fetch;
                    res.page     = ent_page;
                end
                DCODE_CLIENT: begin
                    if (ap_unpred || ap_abort || (is_fetch && ent_xn)) begin
                        res.fault    = 1'b1;
                        res.cls      = CLS_PERM;
                        res.unpred   = ap_unpred;
                        res.prefetch = is_fetch;
                        res.page     = ent_page;
                    end
                end
                default: ;
            endcase
        end

        s_d.vld = req_valid;
        s_d.res = req_valid ? res : s_q.res;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign rsp_valid    = s_q.vld;
    assign rsp_fault    = s_q.res.fault;
    assign rsp_class    = s_q.res.cls;
    assign rsp_prefetch = s_q.res.prefetch;
    assign rsp_page     = s_q.res.page;
    assign rsp_uncached = s_q.res.uncached;
    assign rsp_unpred   = s_q.res.unpred;

    // R13
    rsp_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    // R13
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!rsp_valid && $stable(rsp_class) && $stable(rsp_fault)));

    // R1
    align_not_prefetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_fault && rsp_class == CLS_ALIGN) |-> !rsp_prefetch);

    // R4
    manager_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && mmu_en && !misalign && dom_code == DCODE_MANAGER) |=> !rsp_fault);

    // R5
    unpred_is_perm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_unpred |-> (rsp_fault && rsp_class == CLS_PERM));

    // R11
    clean_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_fault |-> (!rsp_page && !rsp_prefetch && rsp_class == CLS_NONE));

    // R12
    mmu_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !mmu_en && !misalign) |=> !rsp_fault);
endmodule

// File: tb/test_perm_check_top.sv
module test_perm_check_top;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W     = 32;
    localparam int NUM_DOM    = 16;
    localparam int DOM_W      = $clog2(NUM_DOM);
    localparam int DACR_W     = 2 * NUM_DOM;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic [1:0]        acc_kind = '0;
    logic              priv_mode = 1'b0;
    logic              allow_unaligned = 1'b0;
    logic [ADDR_W-1:0] align_mask = '0;
    logic [ADDR_W-1:0] vaddr = '0;
    logic [DOM_W-1:0]  ent_domain = '0;
    logic [2:0]        ent_ap = '0;
    logic              ent_xn = 1'b0;
    logic              ent_page = 1'b0;
    logic              ent_nocache = 1'b0;
    logic [DACR_W-1:0] dom_access = '0;
    logic              align_check_en = 1'b0;
    logic              mmu_en = 1'b0;
    logic              ap_force_en = 1'b0;
    logic              xp_en = 1'b0;
    logic [1:0]        rs_sel = '0;
    logic              remap_en = 1'b0;
    logic              rsp_valid, rsp_fault, rsp_prefetch, rsp_page, rsp_uncached, rsp_unpred;
    logic [1:0]        rsp_class;

    int tests = 0;
    int fails = 0;
    logic [6:0] exp_q [$];
    string      tag_q [$];
    logic [6:0] last_exp = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    perm_check_top #(.ADDR_W(ADDR_W), .NUM_DOM(NUM_DOM)) i_perm_check_top (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .acc_kind(acc_kind),
        .priv_mode(priv_mode), .allow_unaligned(allow_unaligned),
        .align_mask(align_mask), .vaddr(vaddr), .ent_domain(ent_domain),
        .ent_ap(ent_ap), .ent_xn(ent_xn), .ent_page(ent_page),
        .ent_nocache(ent_nocache), .dom_access(dom_access),
        .align_check_en(align_check_en), .mmu_en(mmu_en),
        .ap_force_en(ap_force_en), .xp_en(xp_en), .rs_sel(rs_sel),
        .remap_en(remap_en), .rsp_valid(rsp_valid), .rsp_fault(rsp_fault),
        .rsp_class(rsp_class), .rsp_prefetch(rsp_prefetch), .rsp_page(rsp_page),
        .rsp_uncached(rsp_uncached), .rsp_unpred(rsp_unpred)
    );

    // Reference: {fault, class[1:0], prefetch, page, uncached, unpred}
    function automatic logic [6:0] model();
        logic f, w, unc, ab, up;
        logic [1:0] dc;
        logic [2:0] a;
        f   = (acc_kind == 2'd2);
        w   = (acc_kind == 2'd1);
        unc = mmu_en ? ent_nocache : ~remap_en;
        if (!f && (align_check_en || !allow_unaligned) && ((vaddr & align_mask) != 0))
            return {1'b1, 2'd1, 1'b0, 1'b0, unc, 1'b0};
        if (!mmu_en) return {1'b0, 2'd0, 1'b0, 1'b0, unc, 1'b0};
        dc = 2'((dom_access >> (2 * int'(ent_domain))) & 3);
        if (dc == 2'd3) return {1'b0, 2'd0, 1'b0, 1'b0, unc, 1'b0};
        if (dc == 2'd0) return {1'b1, 2'd2, f, ent_page, unc, 1'b0};
        if (dc == 2'd2) return {1'b1, 2'd3, f, ent_page, unc, 1'b1};
        a  = ap_force_en ? (ent_ap | 3'd1) : ent_ap;
        up = (a == 3'd4);
        case (a)
            3'd0: ab = xp_en ? 1'b1 : (rs_sel == 2'd2) ? w : (rs_sel == 2'd1) ? (w || !priv_mode) : 1'b1;
            3'd1: ab = !priv_mode;
            3'd2: ab = !priv_mode && w;
            3'd5: ab = !priv_mode || w;
            3'd6, 3'd7: ab = w;
            default: ab = 1'b0;
        endcase
        if (up || ab || (f && ent_xn)) return {1'b1, 2'd3, f, ent_page, unc, up};
        return {1'b0, 2'd0, 1'b0, 1'b0, unc, 1'b0};
    endfunction

    task automatic send(input string tag);
        req_valid = 1'b1;
        exp_q.push_back(model());
        tag_q.push_back(tag);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic base_client();
        mmu_en = 1; acc_kind = 0; priv_mode = 1; allow_unaligned = 1; align_check_en = 0;
        align_mask = 32'h3; vaddr = 32'h1000; ent_domain = 0; ent_ap = 3; ent_xn = 0;
        ent_page = 0; ent_nocache = 0; dom_access = {NUM_DOM{2'b01}}; ap_force_en = 0;
        xp_en = 1; rs_sel = 0; remap_en = 0;
    endtask

    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            logic [6:0] act, ex;
            string t;
            act = {rsp_fault, rsp_class, rsp_prefetch, rsp_page, rsp_uncached, rsp_unpred};
            tests++;
            if (exp_q.size() == 0) begin
                fails++;
                $display("FAIL R13 unexpected response act=%h exp=none", act);
            end else begin
                ex = exp_q.pop_front();
                t  = tag_q.pop_front();
                last_exp = ex;
                if (act !== ex) begin
                    fails++;
                    $display("FAIL %s act=%h exp=%h", t, act, ex);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        tests++; fails++;
        $display("FAIL watchdog act=timeout exp=done");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R13 reset state
        tests++;
        if ({rsp_valid, rsp_fault, rsp_class, rsp_prefetch, rsp_page, rsp_uncached, rsp_unpred} !== 8'h00) begin
            fails++;
            $display("FAIL R13 reset act=%b%b%b exp=0", rsp_valid, rsp_fault, rsp_class);
        end
        rst_n = 1'b1;
        @(negedge clk);

        // R1 alignment
        base_client(); acc_kind = 1; vaddr = 32'h1002; allow_unaligned = 0; send("R1 strict");
        allow_unaligned = 1; send("R1 tolerated");
        align_check_en = 1; send("R1 forced check");
        acc_kind = 2; send("R1 fetch exempt");
        acc_kind = 0; dom_access = '0; send("R1 priority over domain");
        // R2 field selection
        base_client(); dom_access = '0; dom_access[11:10] = 2'b01; ent_domain = 5;
        ent_ap = 1; priv_mode = 0; send("R2 domain5 client perm");
        ent_domain = 4; send("R2 domain4 noaccess");
        dom_access[9:8] = 2'b11; send("R2 domain4 manager");
        // R3 domain fault kinds, R11 page flag
        base_client(); dom_access = '0; acc_kind = 2; send("R3 fetch domain");
        acc_kind = 0; ent_page = 1; send("R3 R11 read domain page");
        // R4 manager
        base_client(); dom_access = {NUM_DOM{2'b11}}; ent_ap = 0; acc_kind = 1; priv_mode = 0;
        send("R4 manager write");
        acc_kind = 2; ent_xn = 1; send("R4 manager xn fetch");
        // R5 reserved code
        base_client(); dom_access = {NUM_DOM{2'b10}}; ent_page = 1; send("R5 reserved domain");
        // R6 forcing
        base_client(); ent_ap = 2; priv_mode = 0; acc_kind = 1; send("R6 ap2 unforced");
        ap_force_en = 1; send("R6 ap2 forced");
        ent_ap = 4; send("R6 ap4 forced to 5");
        // R7 table sweep
        base_client();
        for (int a = 1; a < 8; a++) begin
            for (int p = 0; p < 2; p++) begin
                for (int w = 0; w < 2; w++) begin
                    if (a != 4) begin
                        ent_ap = 3'(a); priv_mode = p[0]; acc_kind = w[0] ? 2'd1 : 2'd0;
                        send("R7 ap table");
                    end
                end
            end
        end
        // R8 code 0
        base_client(); ent_ap = 0; xp_en = 1; send("R8 xp set");
        xp_en = 0;
        for (int r = 0; r < 4; r++) begin
            for (int p = 0; p < 2; p++) begin
                for (int w = 0; w < 2; w++) begin
                    rs_sel = 2'(r); priv_mode = p[0]; acc_kind = w[0] ? 2'd1 : 2'd0;
                    send("R8 rs override");
                end
            end
        end
        // R9
        base_client(); ent_ap = 4; send("R9 ap4 read");
        acc_kind = 2; send("R9 ap4 fetch");
        // R10
        base_client(); acc_kind = 2; ent_xn = 1; ent_page = 1; send("R10 xn fetch");
        ent_xn = 0; send("R10 fetch ok");
        acc_kind = 0; ent_xn = 1; send("R10 xn ignored on read");
        ent_ap = 1; priv_mode = 0; send("R10 R11 data perm abort section");
        // R12
        base_client(); mmu_en = 0; dom_access = '0; remap_en = 0; send("R12 off no remap");
        remap_en = 1; send("R12 off remap");
        mmu_en = 1; dom_access = {NUM_DOM{2'b01}}; ent_nocache = 1; send("R12 on nocache");
        // R13 hold while idle
        base_client(); dom_access = '0; ent_page = 1; send("R13 last");
        @(negedge clk); @(negedge clk);
        tests++;
        if (rsp_valid !== 1'b0 ||
            {rsp_fault, rsp_class, rsp_prefetch, rsp_page, rsp_uncached, rsp_unpred} !== last_exp) begin
            fails++;
            $display("FAIL R13 hold act=%b_%h exp=0_%h", rsp_valid,
                {rsp_fault, rsp_class, rsp_prefetch, rsp_page, rsp_uncached, rsp_unpred}, last_exp);
        end
        if (exp_q.size() != 0) begin
            tests++; fails++;
            $display("FAIL R13 missing responses act=%0d exp=0", exp_q.size());
        end
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule